// File: doc/BRIEF.md
# Bubble-Tolerant Flash Code Encoder

This block is the digital back end of a flash converter. It receives the raw comparator word, C1 at the lowest reference tap up to C(W) at the highest, where W = 2^N − 1. On a sample strobe it captures the word. It then removes isolated bubbles by looking at neighbouring comparators. It marks the 1-to-0 boundary on a one-hot line word and encodes the active lines into an N-bit binary code. The code is registered on the clock edge after the capture, so the latency is one clock and a new result can start on every strobe.

A correction-mode input is captured together with the word and selects one of two schemes. The triple scheme marks line j only when the pattern across C(j−1), C(j) and C(j+1) is 1, 1, 0. The vote scheme first replaces every bit by the majority of itself and its two neighbours, and then marks plain 1-to-0 edges on the voted word. Beyond both ends the word is padded with fixed values: C(0) reads 1 and C(W+1) reads 0. If correction still leaves several lines active, the encoder outputs the bitwise OR of their indices.

Top module: `flash_code_encoder`

## Requirements
- R1: On a clock edge with `strobe` high, `therm_in` is captured into the input register. With `strobe` low, the input register holds its value and changes on `therm_in` have no effect on `code_out`.
- R2: `code_out` takes the encoding of the captured word on the clock edge after the capture, and it holds steady while no new capture occurs.
- R3: For a clean thermometer word with k low-order ones, `code_out` equals k in both modes.
- R4: An all-zero word gives code 0 and an all-ones word gives code W, because C(0) is padded with 1 and C(W+1) with 0.
- R5: With `corr_mode` = 0 (triple scheme), line j (1..W) is active only when C(j+1)=0, C(j)=1 and C(j−1)=1. Example for N=4: C1..C6 = 1,1,1,0,1,0 and all higher bits 0 gives code 3.
- R6: With `corr_mode` = 1 (vote scheme), each bit j is replaced by maj(C(j−1), C(j), C(j+1)) using the same padding, and line j is active when voted C(j)=1 and voted C(j+1)=0. Example for N=4: C1..C6 = 1,1,1,0,1,0 gives code 4, and C1..C6 = 1,1,0,1,1,0 gives code 5.
- R7: When several lines are active, `code_out` is the bitwise OR of their indices. Example for N=4 in triple mode: C1..C6 = 1,1,0,1,1,0 activates lines 2 and 5 and gives code 7.
- R8: Synchronous active-high `rst` clears both the input register and `code_out` to zero. `code_out` stays zero until a word is captured.
- R9: `corr_mode` is captured only on a strobe edge, together with the word. Changing it between strobes does not alter `code_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Sample strobe; captures word and mode |
| corr_mode | input | 1 | 0 = triple pattern detection, 1 = majority vote then edge detection |
| therm_in | input | W | Comparator word, bit 0 = C1 (lowest reference) |
| code_out | output | N | Registered binary code |

## Verification
The bound assertions check four behaviours on every cycle: capture on a strobe, a steady output while no strobe arrives, the pop-count result for any clean thermometer word held in the input register, and the cleared output after reset. The bench scenarios cover the parts that depend on bubble patterns: the different results of the two schemes on the same single-bubble word, the OR of several active lines on multi-bubble words, and the padding at both ends. They also show that mode changes made between strobes have no effect.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;

    typedef enum logic {
        CORR_TRIPLE = 1'b0,
        CORR_VOTE   = 1'b1
    } corr_mode_e;

endpackage

// File: rtl/bubble_vote.sv
module bubble_vote #(
    parameter int W = 15
) (
    input  logic [W-1:0] raw_word,
    output logic [W-1:0] voted_word
);
    logic [W+1:0] padded;

    assign padded = {1'b0, raw_word, 1'b1};

    for (genvar j = 1; j <= W; j++) begin : g_vote
        assign voted_word[j-1] = (padded[j-1] & padded[j])
                               | (padded[j]   & padded[j+1])
                               | (padded[j-1] & padded[j+1]);
    end
endmodule

// File: rtl/boundary_detect.sv
module boundary_detect #(
    parameter int W = 15
) (
    input  logic [W-1:0] word,
    input  logic         use_triple,
    output logic [W-1:0] lines
);
    logic [W+1:0] padded;

    assign padded = {1'b0, word, 1'b1};

    for (genvar j = 1; j <= W; j++) begin : g_line
        logic edge_hit;
        assign edge_hit   = padded[j] & ~padded[j+1];
        assign lines[j-1] = use_triple ? (edge_hit & padded[j-1]) : edge_hit;
    end
endmodule

// File: rtl/line_or_encoder.sv
module line_or_encoder #(
    parameter int N = 4,
    parameter int W = 15
) (
    input  logic [W-1:0] lines,
    output logic [N-1:0] code
);
    always_comb begin
        code = '0;
        for (int i = 0; i < W; i++) begin
            if (lines[i]) begin
                code = code | N'(i + 1);
            end
        end
    end
endmodule

// File: rtl/flash_code_encoder.sv
module flash_code_encoder
    import flash_enc_pkg::*;
#(
    parameter int N = 4,
    localparam int W = (1 << N) - 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic         corr_mode,
    input  logic [W-1:0] therm_in,
    output logic [N-1:0] code_out
);
    logic [W-1:0] word_q;
    corr_mode_e   mode_q;
    logic [W-1:0] voted;
    logic [W-1:0] cleaned;
    logic [W-1:0] lines;
    logic [N-1:0] code_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            mode_q <= CORR_TRIPLE;
        end else if (strobe) begin
            word_q <= therm_in;
            mode_q <= corr_mode_e'(corr_mode);
        end
    end

    bubble_vote #(.W(W)) u_vote (
        .raw_word   (word_q),
        .voted_word (voted)
    );

    always_comb begin
        unique case (mode_q)
            CORR_TRIPLE: cleaned = word_q;
            CORR_VOTE:   cleaned = voted;
        endcase
    end

    boundary_detect #(.W(W)) u_detect (
        .word       (cleaned),
        .use_triple (mode_q == CORR_TRIPLE),
        .lines      (lines)
    );

    line_or_encoder #(.N(N), .W(W)) u_enc (
        .lines (lines),
        .code  (code_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code_out <= '0;
        end else begin
            code_out <= code_d;
        end
    end
endmodule

// File: rtl/flash_enc_checker.sv
module flash_enc_checker #(
    parameter int N = 4,
    parameter int W = 15
) (
    input logic         clk,
    input logic         rst,
    input logic         strobe,
    input logic [W-1:0] therm_in,
    input logic [W-1:0] word_q,
    input logic [N-1:0] code_out
);
    // R1: strobe captures the comparator word
    a_r1_capture: assert property (@(posedge clk) disable iff (rst)
        strobe |=> word_q == $past(therm_in));

    // R1: no strobe, no change of the input register
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(word_q));

    // R2: output steady when no capture in the last two edges
    a_r2_steady: assert property (@(posedge clk) disable iff (rst)
        (!$past(strobe) && !$past(strobe, 2)) |-> $stable(code_out));

    // R3: clean thermometer word encodes to its count of ones
    a_r3_clean_count: assert property (@(posedge clk) disable iff (rst)
        ((word_q & (word_q + 1'b1)) == '0) |=> code_out == N'($countones($past(word_q))));

    // R8: reset clears the output
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> code_out == '0);
endmodule

bind flash_code_encoder flash_enc_checker #(.N(N), .W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .therm_in (therm_in),
    .word_q   (word_q),
    .code_out (code_out)
);

// File: tb/sim_flash_code_encoder.sv
module sim_flash_code_encoder;
    localparam int N = 4;
    localparam int W = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         strobe = 1'b0;
    logic         corr_mode = 1'b0;
    logic [W-1:0] therm_in = '0;
    logic [N-1:0] code_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    flash_code_encoder #(.N(N)) u0 (
        .clk       (clk),
        .rst       (rst),
        .strobe    (strobe),
        .corr_mode (corr_mode),
        .therm_in  (therm_in),
        .code_out  (code_out)
    );

    function automatic logic [N-1:0] ref_code(logic [W-1:0] w, logic vote);
        logic [W+1:0] p;
        logic [W+1:0] v;
        logic [N-1:0] r;
        p = {1'b0, w, 1'b1};
        v = p;
        if (vote) begin
            for (int j = 1; j <= W; j++)
                v[j] = (p[j-1] && p[j]) || (p[j] && p[j+1]) || (p[j-1] && p[j+1]);
        end
        r = '0;
        for (int j = 1; j <= W; j++) begin
            if (vote) begin
                if (v[j] && !v[j+1]) r = r | N'(j);
            end else begin
                if (p[j-1] && p[j] && !p[j+1]) r = r | N'(j);
            end
        end
        return r;
    endfunction

    function automatic logic [W-1:0] therm_of(int k);
        logic [W-1:0] t;
        t = '0;
        for (int i = 0; i < k; i++) t[i] = 1'b1;
        return t;
    endfunction

    task automatic check(string req, logic [N-1:0] got, logic [N-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic convert(logic [W-1:0] w, logic m);
        @(negedge clk);
        therm_in  = w;
        corr_mode = m;
        strobe    = 1'b1;
        @(negedge clk);
        strobe    = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [W-1:0] w;
        logic [N-1:0] held;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check("R8 reset state", code_out, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R8 stays zero before capture", code_out, '0);

        convert('0, 1'b0);
        check("R4 all zero triple", code_out, 0);
        convert('1, 1'b0);
        check("R4 all ones triple", code_out, N'(W));
        convert('0, 1'b1);
        check("R4 all zero vote", code_out, 0);
        convert('1, 1'b1);
        check("R4 all ones vote", code_out, N'(W));
        convert(W'(1), 1'b0);
        check("R5 lowest line uses padded C0", code_out, 1);

        convert(W'(6'b010111), 1'b0);
        check("R5 single bubble above edge triple", code_out, 3);
        convert(W'(6'b010111), 1'b1);
        check("R6 single bubble above edge vote", code_out, 4);
        convert(W'(6'b011011), 1'b1);
        check("R6 hole below edge vote", code_out, 5);
        convert(W'(6'b011011), 1'b0);
        check("R7 two lines OR triple", code_out, 7);
        convert(W'(15'b000_0101_0000_0111), 1'b1);
        check("R7 multi bubble vote", code_out, ref_code(W'(15'b000_0101_0000_0111), 1'b1));

        // R1 / R2: changes without strobe have no effect
        convert(W'(7'b0011111), 1'b0);
        held = code_out;
        check("R3 clean five", held, 5);
        @(negedge clk);
        therm_in = '1;
        corr_mode = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 input ignored without strobe", code_out, held);
        // R9: mode change between strobes
        convert(W'(6'b011011), 1'b0);
        held = code_out;
        @(negedge clk);
        corr_mode = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 mode ignored without strobe", code_out, held);
        check("R2 output held", code_out, 7);

        // R1: back-to-back strobes, one result per strobe
        @(negedge clk);
        therm_in = therm_of(3); corr_mode = 1'b0; strobe = 1'b1;
        @(negedge clk);
        therm_in = therm_of(9);
        @(negedge clk);
        strobe = 1'b0;
        check("R2 back to back first", code_out, 3);
        @(negedge clk);
        check("R2 back to back second", code_out, 9);

        for (int it = 0; it < 150; it++) begin
            int k;
            logic m;
            k = int'($urandom_range(0, W));
            m = 1'(int'($urandom_range(0, 1)));
            w = therm_of(k);
            if (it % 3 == 0) begin
                convert(w, m);
                check("R3 random clean", code_out, N'(k));
            end else if (it % 3 == 1) begin
                w[$urandom_range(0, W - 1)] ^= 1'b1;
                convert(w, m);
                check(m ? "R6 random bubble vote" : "R5 random bubble triple",
                      code_out, ref_code(w, m));
            end else begin
                w = W'($urandom);
                convert(w, m);
                check("R7 random word OR", code_out, ref_code(w, m));
            end
        end

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8 reset after run", code_out, '0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule